// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a synchronous host and an external 64K x 8 asynchronous static RAM. The host presents one request at a time (address, write data and a read/write flag) with a valid strobe. The controller runs the corresponding bus cycle on the memory pins, then pulses an acknowledge for one clock. For reads, the byte fetched from the memory appears on the response port in that same cycle.

Every phase of a memory cycle is timed by a counter whose length comes from parameters. The parameters are the clock period and the memory's minimum or maximum timings in nanoseconds. Each phase length is a ceiling division of a timing by the period, and is never shorter than one clock. The controlled phases are address setup, write pulse, write recovery, read access and bus turnaround. A write issued right after a read does not drive the data pins until the memory's output float time has run out. All memory strobes come straight from flip-flops.

The bidirectional data pins are presented as separate output, output-enable and input lines. The pad buffer that joins them sits outside the block.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, both selects are inactive (low-active select high, high-active select low), output enable and write enable are high, the data output enable is low and the acknowledge is low.
- R2: A request is taken only while the controller is idle. Request inputs that change during a cycle have no effect on that cycle's address, data or direction. The acknowledge is high for exactly one clock: the first clock after the selects drop.
- R3: A read holds the selects active, output enable low and write enable high for RD_CYC clocks. RD_CYC is the largest of ceil(read cycle/period), ceil(address access/period) and ceil(output-enable access/period). The byte on the data input at the last of those clocks is returned on the response port together with the acknowledge.
- R4: A write holds write enable low for exactly WP_CYC contiguous clocks. WP_CYC is the largest of ceil(write pulse/period), ceil(data setup/period) and ceil(address-to-end-of-write/period) minus AS_CYC. During those clocks the data pins carry the request's write byte with the output enable high.
- R5: In a write, write enable falls only after the address and selects have been held for at least AS_CYC = max(1, ceil(address setup/period)) clocks. It rises exactly REC_CYC clocks before the selects drop. REC_CYC is the largest of 1, ceil(write recovery/period), ceil(data hold/period) and ceil(write cycle/period) - AS_CYC - WP_CYC. The data pins stay driven through recovery.
- R6: Both selects move together. The memory address is the request address and stays constant for every clock in which the device is selected.
- R7: The data pins are driven only while the device is selected and output enable is high. Output enable and write enable are never low in the same clock.
- R8: At least TURN_CYC = max(1, ceil(float time/period)) clocks with output enable high come before the data pins are driven. The write setup phase lasts exactly max(AS_CYC, TURN_CYC - g) clocks, where g is the number of consecutive output-enable-high clocks counted at the first selected clock of the write.
- R9: A read returns the byte most recently written to that address. Writes to other addresses leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request byte address |
| req_wdata | input | 8 | Write byte |
| req_ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Read byte, valid with acknowledge |
| mem_addr | output | 16 | Memory address pins |
| mem_sel_lo_n | output | 1 | Low-active device select |
| mem_sel_hi | output | 1 | High-active device select |
| mem_oe_n | output | 1 | Low-active output enable |
| mem_we_n | output | 1 | Low-active write enable |
| mem_dq_o | output | 8 | Data driven towards the memory |
| mem_dq_oe | output | 1 | Enable of the data pin drivers |
| mem_dq_i | input | 8 | Data read from the memory pins |

## Verification
Two functions can act in the same clocks: the float countdown that follows a read, and the address-setup count of a write accepted immediately after that read. The bench issues writes straight after reads, with a float time longer than the idle gap, so the two counters run at once. It then requires the setup phase to last exactly max(AS_CYC, TURN_CYC - g) clocks and the first driven clock to see at least TURN_CYC output-enable-high clocks. Writes issued after writes, where only the setup count applies, act as the contrast case. The bench's memory model returns a wrong byte until the access time has passed, so a read phase that is too short is caught.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_SETUP,
        ST_PULSE,
        ST_RECOV
    } seq_state_e;

    // Clocks needed to cover a time span, never fewer than one.
    function automatic int unsigned span_cycles(input int unsigned ns, input int unsigned period_ns);
        int unsigned c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Saturating difference.
    function automatic int unsigned sat_sub(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : 0;
    endfunction

endpackage

// File: rtl/sram_float_guard.sv
module sram_float_guard #(
    parameter int unsigned TURN_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_done,
    input  logic drive_start,
    output logic bus_free
);
    localparam int unsigned GW = $clog2(TURN_CYC + 1);

    // Remaining quiet clocks after output enable rises. Loading TURN_CYC-1
    // and granting at one makes the first driven clock land exactly on the
    // TURN_CYC-th clock with output enable high.
    logic [GW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (rd_done) begin
            left_d = GW'(TURN_CYC - 1);
        end else if (left_q != '0) begin
            left_d = left_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else begin
            left_q <= left_d;
        end
    end

    assign bus_free = (left_q <= GW'(1));

    // R8: the sequencer never starts driving while the float window is open
    p_no_early_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (left_q > GW'(1)) |-> !drive_start);

endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned AW      = 16,
    parameter int unsigned DW      = 8,
    parameter int unsigned RD_CYC  = 9,
    parameter int unsigned AS_CYC  = 1,
    parameter int unsigned WP_CYC  = 7,
    parameter int unsigned REC_CYC = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ack,
    output logic [DW-1:0] rsp_rdata,
    input  logic          bus_free,
    output logic          rd_done,
    output logic          drive_start,
    output logic [AW-1:0] mem_addr,
    output logic          mem_sel_lo_n,
    output logic          mem_sel_hi,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);
    localparam int unsigned MAXC = max_of(max_of(RD_CYC, AS_CYC), max_of(WP_CYC, REC_CYC));
    localparam int unsigned CW   = $clog2(MAXC + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          sel_on;
        logic          oe_on;
        logic          we_on;
        logic          drv;
        logic          ack;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st: ST_IDLE, cnt: '0, addr: '0, wdata: '0, rdata: '0,
        sel_on: 1'b0, oe_on: 1'b0, we_on: 1'b0, drv: 1'b0, ack: 1'b0
    };

    seq_t d, q;

    always_comb begin
        d           = q;
        d.ack       = 1'b0;
        rd_done     = 1'b0;
        drive_start = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid && !q.ack) begin
                    d.addr   = req_addr;
                    d.wdata  = req_wdata;
                    d.sel_on = 1'b1;
                    if (req_write) begin
                        d.st  = ST_SETUP;
                        d.cnt = CW'(AS_CYC - 1);
                    end else begin
                        d.st    = ST_READ;
                        d.cnt   = CW'(RD_CYC - 1);
                        d.oe_on = 1'b1;
                    end
                end
            end
            ST_READ: begin
                if (q.cnt == '0) begin
                    rd_done  = 1'b1;
                    d.rdata  = mem_dq_i;
                    d.ack    = 1'b1;
                    d.sel_on = 1'b0;
                    d.oe_on  = 1'b0;
                    d.st     = ST_IDLE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_SETUP: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (bus_free) begin
                    drive_start = 1'b1;
                    d.st        = ST_PULSE;
                    d.cnt       = CW'(WP_CYC - 1);
                    d.we_on     = 1'b1;
                    d.drv       = 1'b1;
                end
            end
            ST_PULSE: begin
                if (q.cnt == '0) begin
                    d.we_on = 1'b0;
                    d.st    = ST_RECOV;
                    d.cnt   = CW'(REC_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_RECOV: begin
                if (q.cnt == '0) begin
                    d.drv    = 1'b0;
                    d.sel_on = 1'b0;
                    d.ack    = 1'b1;
                    d.st     = ST_IDLE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SEQ_RST;
        end else begin
            q <= d;
        end
    end

    assign req_ack      = q.ack;
    assign rsp_rdata    = q.rdata;
    assign mem_addr     = q.addr;
    assign mem_sel_lo_n = ~q.sel_on;
    assign mem_sel_hi   = q.sel_on;
    assign mem_oe_n     = ~q.oe_on;
    assign mem_we_n     = ~q.we_on;
    assign mem_dq_o     = q.wdata;
    assign mem_dq_oe    = q.drv;

    // R2: completion pulse lasts one clock
    p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.ack |=> !q.ack);

    // R6: address frozen while selected
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sel_on && $past(q.sel_on)) |-> $stable(q.addr));

    // R5: write enable falls only after a selected clock with the address out
    p_we_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.we_on) |-> $past(q.sel_on));

    // R5: write enable already released the clock before deselect
    p_we_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.sel_on) |-> !$past(q.we_on));

    // R7: strobes never both active
    p_oe_we_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.oe_on && q.we_on));

    // R7: pins driven only inside a selected non-read cycle
    p_drive_in_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.drv |-> (q.sel_on && !q.oe_on));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned AW            = 16,
    parameter int unsigned DW            = 8,
    parameter int unsigned CLK_PERIOD_NS = 8,
    parameter int unsigned T_RC_NS       = 70,
    parameter int unsigned T_AA_NS       = 70,
    parameter int unsigned T_OE_NS       = 35,
    parameter int unsigned T_WC_NS       = 70,
    parameter int unsigned T_WP_NS       = 55,
    parameter int unsigned T_AW_NS       = 60,
    parameter int unsigned T_DW_NS       = 30,
    parameter int unsigned T_AS_NS       = 0,
    parameter int unsigned T_WR_NS       = 0,
    parameter int unsigned T_DH_NS       = 0,
    parameter int unsigned T_HZ_NS       = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ack,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_sel_lo_n,
    output logic          mem_sel_hi,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);
    localparam int unsigned RD_CYC = max_of(max_of(span_cycles(T_RC_NS, CLK_PERIOD_NS),
                                                   span_cycles(T_AA_NS, CLK_PERIOD_NS)),
                                            span_cycles(T_OE_NS, CLK_PERIOD_NS));
    localparam int unsigned AS_CYC = span_cycles(T_AS_NS, CLK_PERIOD_NS);
    localparam int unsigned WP_CYC = max_of(max_of(span_cycles(T_WP_NS, CLK_PERIOD_NS),
                                                   span_cycles(T_DW_NS, CLK_PERIOD_NS)),
                                            sat_sub(span_cycles(T_AW_NS, CLK_PERIOD_NS), AS_CYC));
    localparam int unsigned REC_CYC = max_of(max_of(span_cycles(T_WR_NS, CLK_PERIOD_NS),
                                                    span_cycles(T_DH_NS, CLK_PERIOD_NS)),
                                             sat_sub(span_cycles(T_WC_NS, CLK_PERIOD_NS),
                                                     AS_CYC + WP_CYC));
    localparam int unsigned TURN_CYC = span_cycles(T_HZ_NS, CLK_PERIOD_NS);

    logic bus_free;
    logic rd_done;
    logic drive_start;

    sram_float_guard #(
        .TURN_CYC (TURN_CYC)
    ) u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_done     (rd_done),
        .drive_start (drive_start),
        .bus_free    (bus_free)
    );

    sram_phase_seq #(
        .AW      (AW),
        .DW      (DW),
        .RD_CYC  (RD_CYC),
        .AS_CYC  (AS_CYC),
        .WP_CYC  (WP_CYC),
        .REC_CYC (REC_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_ack      (req_ack),
        .rsp_rdata    (rsp_rdata),
        .bus_free     (bus_free),
        .rd_done      (rd_done),
        .drive_start  (drive_start),
        .mem_addr     (mem_addr),
        .mem_sel_lo_n (mem_sel_lo_n),
        .mem_sel_hi   (mem_sel_hi),
        .mem_oe_n     (mem_oe_n),
        .mem_we_n     (mem_we_n),
        .mem_dq_o     (mem_dq_o),
        .mem_dq_oe    (mem_dq_oe),
        .mem_dq_i     (mem_dq_i)
    );

endmodule

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;

    localparam int P = 8;

    function automatic int cd(input int ns);
        int c;
        c = (ns + P - 1) / P;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected phase lengths, derived from the requirements.
    localparam int E_RD   = mx(mx(cd(70), cd(70)), cd(35));
    localparam int E_AA   = cd(70);
    localparam int E_AS   = cd(0);
    localparam int E_WP   = mx(mx(cd(55), cd(30)), cd(60) - E_AS);
    localparam int E_WCC  = cd(70);
    localparam int E_REC  = mx(mx(1, mx(cd(0), cd(0))), E_WCC - E_AS - E_WP);
    localparam int E_TURN = cd(40);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ack;
    logic [7:0]  rsp_rdata;
    logic [15:0] mem_addr;
    logic        mem_sel_lo_n, mem_sel_hi, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_o;
    logic [7:0]  mem_dq_i = '0;

    always #4 clk = ~clk;

    sram_async_ctrl #(
        .CLK_PERIOD_NS (P),
        .T_RC_NS (70), .T_AA_NS (70), .T_OE_NS (35),
        .T_WC_NS (70), .T_WP_NS (55), .T_AW_NS (60), .T_DW_NS (30),
        .T_AS_NS (0),  .T_WR_NS (0),  .T_DH_NS (0),  .T_HZ_NS (40)
    ) dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .req_ack (req_ack), .rsp_rdata (rsp_rdata),
        .mem_addr (mem_addr), .mem_sel_lo_n (mem_sel_lo_n), .mem_sel_hi (mem_sel_hi),
        .mem_oe_n (mem_oe_n), .mem_we_n (mem_we_n),
        .mem_dq_o (mem_dq_o), .mem_dq_oe (mem_dq_oe), .mem_dq_i (mem_dq_i)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory contents model
    logic [7:0] mem_m [int];

    function automatic logic [7:0] mval(input logic [15:0] a);
        if (mem_m.exists(int'(a))) return mem_m[int'(a)];
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // Request bookkeeping shared with the monitor
    logic        cur_wr = 1'b0;
    logic [15:0] cur_addr = '0;
    logic [7:0]  cur_wdata = '0;

    // Cycle-by-cycle monitor and memory model
    bit          prev_sel = 1'b0;
    bit          prev_oe_drv = 1'b0;
    int          oe_hi = 1000;
    int          rd_age = 0;
    int          sel_cnt = 0, setup = 0, we_cnt = 0, rec = 0, g = 0;
    bit          t_rd = 1'b0, t_wr = 1'b0;
    logic [15:0] t_addr = '0;
    logic [7:0]  t_wdata = '0, pend = '0;

    always @(negedge clk) begin
        bit sel, rd_cond;
        if (!rst_n) begin
            // R1 reset values
            chk(mem_sel_lo_n && !mem_sel_hi, "R1", "selects", {mem_sel_lo_n, mem_sel_hi}, 2'b10);
            chk(mem_oe_n && mem_we_n, "R1", "strobes", {mem_oe_n, mem_we_n}, 2'b11);
            chk(!mem_dq_oe && !req_ack, "R1", "drive/ack", {mem_dq_oe, req_ack}, 0);
        end else begin
            sel = !mem_sel_lo_n && mem_sel_hi;
            chk(mem_sel_lo_n == !mem_sel_hi, "R6", "selects together", {mem_sel_lo_n, mem_sel_hi}, 2'b10);
            chk(!(!mem_oe_n && !mem_we_n), "R7", "oe/we both low", {mem_oe_n, mem_we_n}, 2'b11);
            if (mem_dq_oe) chk(sel && mem_oe_n, "R7", "drive outside write", {sel, mem_oe_n}, 2'b11);

            if (mem_oe_n) oe_hi++; else oe_hi = 0;

            if (mem_dq_oe && !prev_oe_drv)
                chk(oe_hi >= E_TURN, "R8", "oe-high clocks before drive", oe_hi, E_TURN);

            if (sel && !prev_sel) begin
                t_addr = mem_addr; t_wdata = cur_wdata;
                t_rd = !mem_oe_n; t_wr = cur_wr;
                sel_cnt = 1; setup = 0; we_cnt = 0; rec = 0; g = oe_hi;
                chk(mem_addr == cur_addr, "R6", "bus address", mem_addr, cur_addr);
                chk(t_rd == !cur_wr, "R2", "direction", t_rd, !cur_wr);
            end else if (sel) begin
                sel_cnt++;
                chk(mem_addr == t_addr, "R6", "address moved", mem_addr, t_addr);
            end

            if (sel) begin
                if (t_rd) chk(!mem_oe_n && mem_we_n, "R3", "read strobes", {mem_oe_n, mem_we_n}, 2'b01);
                if (mem_we_n) begin
                    if (we_cnt == 0) setup++; else rec++;
                    if (we_cnt != 0) chk(mem_dq_oe, "R5", "drive through recovery", mem_dq_oe, 1);
                end else begin
                    chk(rec == 0, "R4", "pulse contiguous", rec, 0);
                    we_cnt++;
                    chk(mem_dq_oe && mem_dq_o == t_wdata, "R4", "write data", mem_dq_o, t_wdata);
                    pend = mem_dq_o;
                end
            end

            // R2 acknowledge exactly on the first deselected clock
            chk(req_ack == (prev_sel && !sel), "R2", "ack timing", req_ack, prev_sel && !sel);

            if (prev_sel && !sel) begin
                if (t_rd) begin
                    chk(sel_cnt == E_RD, "R3", "read length", sel_cnt, E_RD);
                    chk(rsp_rdata == mval(t_addr), "R9", "read data", rsp_rdata, mval(t_addr));
                end else begin
                    mem_m[int'(t_addr)] = pend;
                    chk(we_cnt == E_WP, "R4", "pulse length", we_cnt, E_WP);
                    chk(setup == mx(E_AS, E_TURN - g), "R8", "setup length", setup, mx(E_AS, E_TURN - g));
                    chk(setup >= E_AS, "R5", "address setup", setup, E_AS);
                    chk(rec == E_REC, "R5", "recovery length", rec, E_REC);
                    chk(sel_cnt >= E_WCC, "R5", "write cycle length", sel_cnt, E_WCC);
                end
            end

            // Memory read model: wrong byte until the access time has elapsed
            rd_cond = sel && !mem_oe_n && mem_we_n;
            if (rd_cond) rd_age++; else rd_age = 0;
            mem_dq_i = (rd_cond && rd_age >= E_AA) ? mval(mem_addr) : ~mval(mem_addr);

            prev_sel = sel;
            prev_oe_drv = mem_dq_oe;
        end
    end

    task automatic xfer(input logic wr, input logic [15:0] a, input logic [7:0] dv, input bit disturb);
        int n;
        @(negedge clk);
        cur_wr = wr; cur_addr = a; cur_wdata = dv;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dv;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (req_ack) break;
            if (disturb && n == 2) begin
                req_addr = ~a; req_wdata = ~dv; req_write = ~wr;
            end
            if (n > 64) begin
                chk(1'b0, "R2", "request never acknowledged", n, 0);
                break;
            end
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R2", "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        xfer(1'b1, 16'h1234, 8'h5A, 1'b0);   // write after idle
        xfer(1'b1, 16'h1235, 8'hC3, 1'b0);   // write after write
        xfer(1'b0, 16'h1234, 8'h00, 1'b0);   // read back (R9)
        xfer(1'b1, 16'h1236, 8'h81, 1'b0);   // write right after read (R8 overlap)
        xfer(1'b0, 16'hBEEF, 8'h00, 1'b0);   // unwritten location
        xfer(1'b0, 16'h1235, 8'h00, 1'b0);
        xfer(1'b1, 16'h0000, 8'hFF, 1'b1);   // boundary, inputs disturbed (R2)
        xfer(1'b1, 16'hFFFF, 8'h00, 1'b1);
        xfer(1'b0, 16'h0000, 8'h00, 1'b1);
        xfer(1'b0, 16'hFFFF, 8'h00, 1'b0);
        xfer(1'b0, 16'h1236, 8'h00, 1'b0);
        for (int i = 0; i < 8; i++) begin
            xfer(1'b1, 16'h4000 + 16'(i), 8'(i * 37 + 5), 1'b0);
            xfer(1'b0, 16'h4000 + 16'((i * 3) % 8), 8'h00, 1'b0);
        end
        xfer(1'b1, 16'h1234, 8'h77, 1'b0);   // overwrite, neighbour untouched
        xfer(1'b0, 16'h1235, 8'h00, 1'b0);
        xfer(1'b0, 16'h1234, 8'h00, 1'b0);
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule